// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiply-Accumulate Unit

This block multiplies two 32-bit operands over several clock cycles and returns the low 32 bits of the product. An optional addend can be added in the same pass. Each cycle it consumes two bits of the multiplier. The two-bit digit and a one-bit carry left over from the previous cycle are recoded into one of five actions: leave the running sum alone, add the shifted multiplicand, add it doubled, subtract it, or subtract it doubled. A single adder/subtractor handles every cycle.

A caller presents the operands with a one-cycle `start` pulse while the unit is idle. `busy` stays high while the iterations run. `done` then pulses for one cycle, and `result` holds its value until the next completion. The run stops early once the unconsumed multiplier bits and the carry are all zero, so small multipliers finish in a few cycles.

Top module: `booth4_mac`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done` and `result` are all zero.
- R2: A `start` pulse sampled while `busy` is low latches `mcand`, `mplr`, `acc_en` and `addend`, and raises `busy` at that same clock edge.
- R3: With `acc_en` low, `result` equals (`mplr` × `mcand`) mod 2^32.
- R4: With `acc_en` high, `result` equals (`mplr` × `mcand` + `addend`) mod 2^32. With `acc_en` low, `addend` has no effect.
- R5: Iteration n looks at multiplier bits [2n+1:2n] and the carry c. It applies these steps, where T = `mcand`<<2n: c=0 with digit 0 adds nothing and leaves c=0; c=0 with digit 1 adds T and leaves c=0; c=0 with digit 2 subtracts 2T and leaves c=1; c=0 with digit 3 subtracts T and leaves c=1; c=1 with digit 0 adds T and leaves c=0; c=1 with digit 1 adds 2T and leaves c=0; c=1 with digit 2 subtracts T and leaves c=1; c=1 with digit 3 adds nothing and leaves c=1. The carry starts at 0.
- R6: Let h be the index of the highest set bit of `mplr`. The run takes L = min(16, floor((h+1)/2)+1) iterations, or L = 1 when `mplr` is zero. `busy` is high for exactly L cycles, and `done` rises at the edge where `busy` falls.
- R7: `done` is high for exactly one cycle per run. `result` changes only at the edge that raises `done`.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The run in progress finishes with its original operands and its original timing.
- R9: Every bit that would land above bit 31, including the final carry left after 16 iterations, is dropped. For example, 0x80000000 × 0x80000000 gives 0, and 0xFFFFFFFF × 0xFFFFFFFF gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run; only taken while idle |
| mcand | input | 32 | Multiplicand |
| mplr | input | 32 | Multiplier, consumed two bits per cycle from the low end |
| acc_en | input | 1 | When high, the running sum starts from `addend` |
| addend | input | 32 | Value added to the product when `acc_en` is high |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 32 | Low 32 bits of the product plus the optional addend |

## Verification
The bench chooses multipliers that step through every digit/carry pair of the recoding table: alternating bit patterns, all-ones, and a lone top bit. A wrong entry in that table, or a wrong doubling or subtraction choice, shows up as a bad product. Single-bit multipliers at each position check the early stop. A stop one iteration too soon drops the last term, and a stop one too late shows up as a busy period of the wrong length, because `busy` and `done` are compared on every clock. Products that spill above bit 31 and an ignored `start` in the middle of a run check that overflow wraps and that the operands cannot be overwritten while a run is in progress.

// File: rtl/booth4_pkg.sv
package booth4_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } op_e;

  typedef struct packed {
    op_e  op;    // what to do with the term
    logic dbl;   // use twice the shifted multiplicand
    logic cout;  // carry handed to the next digit
  } step_t;
endpackage

// File: rtl/booth4_recode.sv
module booth4_recode
  import booth4_pkg::*;
(
  input  logic [1:0] digit,
  input  logic       cin,
  output step_t      step
);
  always_comb begin
    step = '{op: OP_NONE, dbl: 1'b0, cout: 1'b0};
    unique case ({cin, digit})
      3'b0_00: step = '{op: OP_NONE, dbl: 1'b0, cout: 1'b0};
      3'b0_01: step = '{op: OP_ADD,  dbl: 1'b0, cout: 1'b0};
      3'b0_10: step = '{op: OP_SUB,  dbl: 1'b1, cout: 1'b1};
      3'b0_11: step = '{op: OP_SUB,  dbl: 1'b0, cout: 1'b1};
      3'b1_00: step = '{op: OP_ADD,  dbl: 1'b0, cout: 1'b0};
      3'b1_01: step = '{op: OP_ADD,  dbl: 1'b1, cout: 1'b0};
      3'b1_10: step = '{op: OP_SUB,  dbl: 1'b0, cout: 1'b1};
      3'b1_11: step = '{op: OP_NONE, dbl: 1'b0, cout: 1'b1};
      default: step = '{op: OP_NONE, dbl: 1'b0, cout: 1'b0};
    endcase
  end
endmodule

// File: rtl/booth4_addsub.sv
module booth4_addsub
  import booth4_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] base,
  input  logic             dbl,
  input  op_e              op,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] term;
  logic [WIDTH-1:0] operand;
  logic             sub;

  always_comb begin
    sub     = (op == OP_SUB);
    term    = dbl ? {base[WIDTH-2:0], 1'b0} : base;
    if (op == OP_NONE) term = '0;
    operand = sub ? ~term : term;
    sum     = acc + operand + {{(WIDTH-1){1'b0}}, sub};
  end
endmodule

// File: rtl/booth4_mac.sv
module booth4_mac
  import booth4_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplr,
  input  logic             acc_en,
  input  logic [WIDTH-1:0] addend,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  localparam int STEPS = WIDTH / 2;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

  logic [WIDTH-1:0] acc_q, mc_q, mp_q, mp_next, sum;
  logic             carry_q, last;
  logic [CW-1:0]    cnt_q;
  step_t            st;

  booth4_recode u_rec (
    .digit (mp_q[1:0]),
    .cin   (carry_q),
    .step  (st)
  );

  booth4_addsub #(.WIDTH(WIDTH)) u_add (
    .acc  (acc_q),
    .base (mc_q),
    .dbl  (st.dbl),
    .op   (st.op),
    .sum  (sum)
  );

  always_comb begin
    mp_next = mp_q >> 2;
    last    = ((mp_next == '0) && !st.cout) || (cnt_q == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      acc_q   <= '0;
      mc_q    <= '0;
      mp_q    <= '0;
      carry_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          acc_q   <= acc_en ? addend : '0;
          mc_q    <= mcand;
          mp_q    <= mplr;
          carry_q <= 1'b0;
          cnt_q   <= '0;
        end
      end else begin
        acc_q   <= sum;
        mp_q    <= mp_next;
        mc_q    <= mc_q << 2;
        carry_q <= st.cout;
        cnt_q   <= cnt_q + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/booth4_mac_chk.sv
module booth4_mac_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  localparam int STEPS = WIDTH / 2;
  localparam int RW    = $clog2(STEPS + 2);

  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_after_run_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  p_run_bound_r6: assert property (@(posedge clk) disable iff (rst)
    run_q <= RW'(STEPS));
endmodule

bind booth4_mac booth4_mac_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/booth4_mac_tb_top.sv
module booth4_mac_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] mcand = '0, mplr = '0, addend = '0;
  logic        acc_en = 1'b0;
  logic        busy, done;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  booth4_mac #(.WIDTH(32)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplr(mplr),
    .acc_en(acc_en), .addend(addend), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [31:0] m);
    int h = -1;
    for (int i = 0; i < 32; i++) if (m[i]) h = i;
    if (h < 0) return 1;
    if ((h + 1) / 2 + 1 > 16) return 16;
    return (h + 1) / 2 + 1;
  endfunction

  // Runs one operation; intr_at >= 0 injects an ignored start (R8) at that busy cycle.
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic en,
                        input logic [31:0] add, input int intr_at, input string tag);
    logic [31:0] exp_res, prev;
    int len;
    exp_res = b * a + (en ? add : 32'd0);
    len = exp_len(b);
    prev = result;
    @(negedge clk);
    mcand = a; mplr = b; acc_en = en; addend = add; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mcand = ~a; mplr = 32'h0000_0003; addend = ~add; acc_en = ~en;
    for (int i = 0; i < len; i++) begin
      check({"R2/R6 busy ", tag}, {31'd0, busy}, 32'd1);
      check({"R7 done low ", tag}, {31'd0, done}, 32'd0);
      check({"R7 result hold ", tag}, result, prev);
      if (i == intr_at) begin
        start = 1'b1; mplr = 32'hFFFF_FFFF; mcand = 32'h1234_5678;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check({"R6 busy fall ", tag}, {31'd0, busy}, 32'd0);
    check({"R7 done pulse ", tag}, {31'd0, done}, 32'd1);
    check({"R3/R4/R5 result ", tag}, result, exp_res);
    @(negedge clk);
    check({"R7 done single ", tag}, {31'd0, done}, 32'd0);
    check({"R7 result stable ", tag}, result, exp_res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'd0, busy}, 32'd0);
    check("R1 done in reset", {31'd0, done}, 32'd0);
    check("R1 result in reset", result, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", {31'd0, busy}, 32'd0);
    check("R1 result after reset", result, 32'd0);

    run_op(32'd7, 32'd0, 1'b0, 32'd0, -1, "R3 zero mplr");
    run_op(32'd0, 32'hDEAD_BEEF, 1'b0, 32'd0, -1, "R3 zero mcand");
    run_op(32'd1, 32'd1, 1'b0, 32'd0, -1, "R3 one");
    run_op(32'h1234_5678, 32'h5555_5555, 1'b0, 32'd0, -1, "R5 digit1");
    run_op(32'h1234_5678, 32'hAAAA_AAAA, 1'b0, 32'd0, -1, "R5 digit2");
    run_op(32'h0F0F_0F0F, 32'h9999_9999, 1'b0, 32'd0, -1, "R5 mixed");
    run_op(32'h0BAD_F00D, 32'h6E6E_6E6E, 1'b0, 32'd0, -1, "R5 mixed2");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'd0, -1, "R9 ones");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 32'd0, -1, "R9 top bit");
    run_op(32'h8000_0000, 32'd3, 1'b0, 32'd0, -1, "R9 spill");
    run_op(32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 32'h0000_0001, -1, "R4 R9 mac");
    run_op(32'd25, 32'd4, 1'b1, 32'hFFFF_FF00, -1, "R4 mac");
    run_op(32'd25, 32'd4, 1'b0, 32'hFFFF_FF00, -1, "R4 addend ignored");
    for (int p = 0; p < 32; p++)
      run_op(32'h0137_ACE5, 32'd1 << p, 1'b0, 32'd0, -1, "R6 single bit");
    run_op(32'h0000_1111, 32'h00F0_0000, 1'b0, 32'd0, 2, "R8 start while busy");
    run_op(32'h7654_3210, 32'h0000_0002, 1'b1, 32'd99, 0, "R8 start first busy");
    for (int k = 0; k < 150; k++)
      run_op($urandom, (k % 3 == 0) ? ($urandom >> (k % 32)) : $urandom,
             1'(k % 2), $urandom, -1, "R3 R4 random");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual=%0d cycles expected=end of run", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule